// File: doc/BRIEF.md
# Receive Descriptor-Ring DMA Engine

This block is one receive channel. It takes frames from a byte stream and writes each frame into a memory buffer that software has prepared. Software describes the buffers in a chain of descriptors in memory. Each descriptor says whether the engine owns it, how large its buffer is, where the buffer lives and where the following descriptor sits. The engine walks this chain. It stores each frame through a 32-bit memory master, writes the outcome back into the descriptor and hands ownership back to software.

Three write-only registers drive the engine: an enable bit with a self-clearing start strobe, the address of the first descriptor, and a poll interval in clock cycles. A descriptor that is not yet owned by the engine is fetched again after the poll interval. The strobe cuts that wait short. The engine never fetches a descriptor unless a frame is waiting at its input. A descriptor flagged as the final one stops the walk until software strobes again.

Top module: `rxring_dma`

## Requirements
- R1: Out of reset, `s_ready` and `mem_req` are low. The engine stays idle, with no memory access, until a start strobe arrives with the enable bit set.
- R2: A descriptor is four 32-bit words at byte offsets +0 status, +4 control, +8 buffer address and +12 next-descriptor address. Control bit 31 is engine ownership, bit 30 is direction, bit 29 is last fragment, bit 28 is final descriptor, and bits 15:0 are a byte length. The buffer capacity is the length field when the descriptor is armed.
- R3: Frame byte k is stored at buffer address + k, in byte lane k mod 4 of the little-endian word at (buffer + k) rounded down to a multiple of 4, with `mem_be` marking the written lanes. Bytes of the buffer past the stored length keep their old values.
- R4: At frame end the engine writes status first and control second. The control word has bit 31 cleared, bit 29 set, bits 30 and 28 kept as armed, and bits 15:0 set to the stored byte count. Status is 0 for a frame that fit.
- R5: A frame longer than the capacity is cut to the capacity. Excess bytes are accepted and dropped up to the end marker. Status bit 0 is set to 1 and the length field equals the capacity.
- R6: After a descriptor completes, the engine moves to the address in its next word, so a chain whose last next word points at the first forms a ring.
- R7: If the fetched control word has bit 31 clear, the engine accepts no data. It reads control again once the programmed poll interval has passed, and it repeats this for as long as a frame is pending.
- R8: A start strobe during a poll wait ends the wait at once and triggers a new fetch.
- R9: While `s_valid` is low, the engine issues no descriptor fetch, even if a strobe is given.
- R10: After completing a descriptor whose bit 28 is set, the engine halts. It issues no memory access and does not raise `s_ready` until a new start strobe.
- R11: Writing the base-address register while the engine is halted or idle makes that address the next descriptor to fetch.
- R12: `s_ready` is low whenever a descriptor is read or written. Once `mem_req` is high, the request holds its address, direction and data until `mem_ready` is high.
- R13: While the enable bit is clear, the engine starts no new descriptor fetch.

Register map on `csr_addr`: 0 is control (bit 0 enable, bit 1 start strobe, applied only if bit 0 is also 1 in the same write). 1 is the descriptor base address. 2 is the poll interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select |
| csr_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Byte address of the word accessed |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Byte ends the frame |
| s_ready | output | 1 | Engine accepts the byte |

## Verification
The bench builds the engine with its defaults: 32-bit addresses, a 16-bit length counter, little-endian lane order and a 16-bit poll counter. A 16-bit poll counter lets the bench set one interval short enough to count several refetches in a short window, and another long enough that only the strobe can end the wait. With 64-byte buffers and a four-entry ring, frames of 1 to 70 bytes reach every lane alignment, exact fill and truncation, and the ring wraps twice. The memory model can insert wait states, which exercises request holding.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   // descriptor word byte offsets
   localparam int unsigned OFS_STAT = 0;
   localparam int unsigned OFS_CTRL = 4;
   localparam int unsigned OFS_BUF  = 8;
   localparam int unsigned OFS_NEXT = 12;

   // control word bit positions
   localparam int unsigned CB_OWN   = 31;
   localparam int unsigned CB_DIR   = 30;
   localparam int unsigned CB_LFRAG = 29;
   localparam int unsigned CB_FINAL = 28;

   // register select codes
   localparam logic [1:0] RS_CTRL = 2'd0;
   localparam logic [1:0] RS_BASE = 2'd1;
   localparam logic [1:0] RS_POLL = 2'd2;

   typedef enum logic [3:0] {
      ST_IDLE, ST_WAIT, ST_RDCTRL, ST_RDBUF, ST_RDNEXT,
      ST_POLL, ST_DATA, ST_WBSTAT, ST_WBCTRL
   } rxd_state_e;
endpackage

// File: rtl/rxd_csr.sv
module rxd_csr
   import rxd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int POLL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic [1:0]        csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic              enable,
   output logic              strobe,
   output logic              base_wr,
   output logic [ADDR_W-1:0] base_val,
   output logic [POLL_W-1:0] poll_period
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable      <= 1'b0;
         strobe      <= 1'b0;
         base_wr     <= 1'b0;
         base_val    <= '0;
         poll_period <= '0;
      end else begin
         strobe  <= csr_wr && (csr_addr == RS_CTRL) && csr_wdata[1] && csr_wdata[0];
         base_wr <= csr_wr && (csr_addr == RS_BASE);
         if (csr_wr && csr_addr == RS_CTRL) enable      <= csr_wdata[0];
         if (csr_wr && csr_addr == RS_BASE) base_val    <= csr_wdata[ADDR_W-1:0];
         if (csr_wr && csr_addr == RS_POLL) poll_period <= csr_wdata[POLL_W-1:0];
      end
   end

   a_r13_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> enable);
endmodule

// File: rtl/rxd_poll.sv
module rxd_poll #(
   parameter int POLL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [POLL_W-1:0] period,
   input  logic              strobe,
   output logic              expire
);
   logic [POLL_W-1:0] cnt_q;
   logic              run_q;

   assign expire = run_q && (strobe || (({1'b0, cnt_q} + 1'b1) >= {1'b0, period}));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (arm) begin
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (expire) run_q <= 1'b0;
         else        cnt_q <= cnt_q + 1'b1;
      end
   end

   a_r8_strobe_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && strobe && !arm |=> !run_q);
endmodule

// File: rtl/rxd_packer.sv
module rxd_packer #(
   parameter int LEN_W      = 16,
   parameter bit LITTLE_END = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [LEN_W-1:0] cap,
   input  logic             take,
   input  logic [7:0]       din,
   input  logic             dlast,
   input  logic             ack,
   output logic [31:0]      word,
   output logic [3:0]       be,
   output logic             pending,
   output logic             eof,
   output logic             ovf,
   output logic [LEN_W-1:0] count,
   output logic [LEN_W-1:0] woff
);
   logic [LEN_W-1:0] cnt_q, cap_q;
   logic [3:0]       be_q;
   logic [31:0]      word_q, word_nx;
   logic             eof_q, ovf_q, store;
   logic [1:0]       lane;

   if (LITTLE_END) begin : g_le
      assign lane = cnt_q[1:0];
   end else begin : g_be
      assign lane = 2'd3 - cnt_q[1:0];
   end

   assign store = take && (cnt_q < cap_q);

   for (genvar k = 0; k < 4; k++) begin : g_lane
      assign word_nx[8*k +: 8] = (store && lane == 2'(k)) ? din : word_q[8*k +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         cap_q  <= '0;
         be_q   <= '0;
         word_q <= '0;
         eof_q  <= 1'b0;
         ovf_q  <= 1'b0;
      end else if (clear) begin
         cnt_q <= '0;
         cap_q <= cap;
         be_q  <= '0;
         eof_q <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         if (ack) be_q <= '0;
         word_q <= word_nx;
         if (store) begin
            be_q[lane] <= 1'b1;
            cnt_q      <= cnt_q + 1'b1;
         end else if (take) begin
            ovf_q <= 1'b1;
         end
         if (take && dlast) eof_q <= 1'b1;
      end
   end

   assign word    = word_q;
   assign be      = be_q;
   assign pending = (be_q == 4'hF) || (eof_q && be_q != 4'h0);
   assign eof     = eof_q;
   assign ovf     = ovf_q;
   assign count   = cnt_q;
   assign woff    = (cnt_q - 1'b1) & ~LEN_W'(3);

   a_r5_no_store_past_cap: assert property (@(posedge clk) disable iff (!rst_n)
      !clear && take && (cnt_q >= cap_q) |=> $stable(cnt_q) && ovf_q);
   a_r12_no_take_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> !take);
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
   import rxd_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int POLL_W     = 16,
   parameter bit LITTLE_END = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic [1:0]        csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ready,
   input  logic [31:0]       mem_rdata,
   input  logic              s_valid,
   input  logic [7:0]        s_data,
   input  logic              s_last,
   output logic              s_ready
);
   if (ADDR_W < 16 || ADDR_W > 32) begin : g_bad_addr
      $error("rxring_dma: ADDR_W must lie in 16..32");
   end
   if (LEN_W < 2 || LEN_W > 16) begin : g_bad_len
      $error("rxring_dma: LEN_W must lie in 2..16");
   end
   if (POLL_W < 1 || POLL_W > 32) begin : g_bad_poll
      $error("rxring_dma: POLL_W must lie in 1..32");
   end

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_BUF  = ADDR_W'(OFS_BUF);
   localparam logic [ADDR_W-1:0] A_NEXT = ADDR_W'(OFS_NEXT);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

   logic              enable, strobe, base_wr;
   logic [ADDR_W-1:0] base_val;
   logic [POLL_W-1:0] poll_period;
   logic              poll_arm, poll_expire;

   rxd_state_e        state;
   logic [ADDR_W-1:0] cur_q, nxt_q, buf_q;
   logic [31:0]       ctl_q, wb_ctrl;

   logic              pk_clear, pk_take, pk_ack, pk_pending, pk_eof, pk_ovf;
   logic [31:0]       pk_word;
   logic [3:0]        pk_be;
   logic [LEN_W-1:0]  pk_count, pk_woff;

   rxd_csr #(.ADDR_W(ADDR_W), .POLL_W(POLL_W)) u_csr (
      .clk, .rst_n, .csr_wr, .csr_addr, .csr_wdata,
      .enable, .strobe, .base_wr, .base_val, .poll_period
   );

   rxd_poll #(.POLL_W(POLL_W)) u_poll (
      .clk, .rst_n, .arm(poll_arm), .period(poll_period),
      .strobe, .expire(poll_expire)
   );

   rxd_packer #(.LEN_W(LEN_W), .LITTLE_END(LITTLE_END)) u_pack (
      .clk, .rst_n, .clear(pk_clear), .cap(ctl_q[LEN_W-1:0]),
      .take(pk_take), .din(s_data), .dlast(s_last), .ack(pk_ack),
      .word(pk_word), .be(pk_be), .pending(pk_pending), .eof(pk_eof),
      .ovf(pk_ovf), .count(pk_count), .woff(pk_woff)
   );

   assign s_ready  = (state == ST_DATA) && !pk_pending && !pk_eof;
   assign pk_take  = s_valid && s_ready;
   assign pk_ack   = (state == ST_DATA) && pk_pending && mem_ready;
   assign pk_clear = (state == ST_RDNEXT) && mem_ready;
   assign poll_arm = (state == ST_RDCTRL) && mem_ready && !mem_rdata[CB_OWN];

   always_comb begin
      wb_ctrl           = ctl_q;
      wb_ctrl[CB_OWN]   = 1'b0;
      wb_ctrl[CB_LFRAG] = 1'b1;
      wb_ctrl[15:0]     = 16'(pk_count);
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_q;
      mem_be    = 4'hF;
      mem_wdata = '0;
      unique case (state)
         ST_RDCTRL: begin mem_req = 1'b1; mem_addr = cur_q + A_CTRL; end
         ST_RDBUF:  begin mem_req = 1'b1; mem_addr = cur_q + A_BUF;  end
         ST_RDNEXT: begin mem_req = 1'b1; mem_addr = cur_q + A_NEXT; end
         ST_DATA: begin
            mem_req   = pk_pending;
            mem_we    = 1'b1;
            mem_addr  = buf_q + ADDR_W'(pk_woff);
            mem_be    = pk_be;
            mem_wdata = pk_word;
         end
         ST_WBSTAT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_q + A_STAT;
            mem_wdata = {31'd0, pk_ovf};
         end
         ST_WBCTRL: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_q + A_CTRL;
            mem_wdata = wb_ctrl;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cur_q <= '0;
         nxt_q <= '0;
         buf_q <= '0;
         ctl_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (base_wr) cur_q <= base_val;
               if (strobe)  state <= ST_WAIT;
            end
            ST_WAIT: if (enable && s_valid) state <= ST_RDCTRL;
            ST_RDCTRL: if (mem_ready) begin
               ctl_q <= mem_rdata;
               state <= mem_rdata[CB_OWN] ? ST_RDBUF : ST_POLL;
            end
            ST_POLL: if (poll_expire) state <= ST_WAIT;
            ST_RDBUF: if (mem_ready) begin
               buf_q <= mem_rdata[ADDR_W-1:0];
               state <= ST_RDNEXT;
            end
            ST_RDNEXT: if (mem_ready) begin
               nxt_q <= mem_rdata[ADDR_W-1:0];
               state <= ST_DATA;
            end
            ST_DATA: if (pk_eof && !pk_pending) state <= ST_WBSTAT;
            ST_WBSTAT: if (mem_ready) state <= ST_WBCTRL;
            ST_WBCTRL: if (mem_ready) begin
               cur_q <= nxt_q;
               state <= ctl_q[CB_FINAL] ? ST_IDLE : ST_WAIT;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata) && $stable(mem_be));
   a_r12_no_ready_on_desc: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && (!mem_we || state != ST_DATA) |-> !s_ready);
   a_r4_status_before_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WBCTRL) |-> ($past(state) == ST_WBSTAT || $past(state) == ST_WBCTRL));
   a_r9_fetch_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) && !s_valid |=> state != ST_RDCTRL);
   a_r10_halt_until_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) && !strobe |=> (state == ST_IDLE) && !mem_req);
   a_r13_no_fetch_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) && !enable |=> state == ST_WAIT);
endmodule

// File: tb/rxring_dma_bench.sv
`timescale 1ns/1ps
module rxring_dma_bench;
   localparam int NV = 9;
   localparam int V_LEN [NV] = '{1, 4, 5, 7, 60, 64, 70, 3, 8};
   localparam int V_CAP [NV] = '{64, 64, 64, 64, 64, 64, 64, 2, 8};
   localparam bit V_STALL [NV] = '{0, 1, 0, 1, 0, 1, 1, 0, 1};
   localparam bit V_LFARM [NV] = '{1, 0, 1, 0, 1, 0, 1, 1, 0};

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        csr_wr = 1'b0;
   logic [1:0]  csr_addr = '0;
   logic [31:0] csr_wdata = '0;
   logic        mem_req, mem_we, mem_ready, s_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_be;
   logic        s_valid = 1'b0, s_last = 1'b0;
   logic [7:0]  s_data = '0;

   logic [31:0] mem [256];
   logic        stall = 1'b0;
   int          rdy_ctr = 0;
   int          req_total = 0, rdy_total = 0;
   int          n_chk = 0, n_bad = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   rxring_dma u_rxring_dma (
      .clk, .rst_n, .csr_wr, .csr_addr, .csr_wdata,
      .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_ready, .mem_rdata,
      .s_valid, .s_data, .s_last, .s_ready
   );

   assign mem_rdata = mem[mem_addr[9:2]];

   always @(negedge clk) begin
      rdy_ctr   <= rdy_ctr + 1;
      mem_ready <= !stall || (rdy_ctr % 3 != 0);
   end

   always @(posedge clk) begin
      if (mem_req && mem_ready) req_total <= req_total + 1;
      if (s_ready) rdy_total <= rdy_total + 1;
      if (mem_req && mem_we && mem_ready)
         for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[mem_addr[9:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
   end

   function automatic int dw(int r); return 16 + 4 * r; endfunction
   function automatic int bw(int r); return 64 + 16 * r; endfunction

   task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic csr(logic [1:0] a, logic [31:0] d);
      csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_wr = 1'b0;
   endtask

   task automatic arm(int r, logic [31:0] ctrl);
      mem[dw(r)]     = 32'hDEAD_BEEF;
      mem[dw(r) + 1] = ctrl;
      for (int j = 0; j < 16; j++) mem[bw(r) + j] = 32'hEEEE_EEEE;
   endtask

   task automatic send(int len, logic [7:0] pat);
      for (int j = 0; j < len; j++) begin
         s_valid = 1'b1; s_data = pat + 8'(j); s_last = (j == len - 1);
         while (!s_ready) @(negedge clk);
         @(negedge clk);
      end
      s_valid = 1'b0; s_last = 1'b0;
   endtask

   task automatic wait_done(int r, int limit, string what);
      int t = 0;
      while (mem[dw(r) + 1][31] && t < limit) begin @(negedge clk); t++; end
      chk(!mem[dw(r) + 1][31], what, mem[dw(r) + 1], {1'b0, mem[dw(r) + 1][30:0]});
   endtask

   // R2 R3 R4 R5: descriptor write-back and buffer contents
   task automatic check_frame(int r, int len, int cap, logic [7:0] pat, logic [31:0] hi);
      int kept = (len > cap) ? cap : len;
      int bad = -1;
      logic [7:0] got;
      chk(mem[dw(r)] == ((len > cap) ? 32'd1 : 32'd0), "R5 status word", mem[dw(r)],
          (len > cap) ? 32'd1 : 32'd0);
      chk(mem[dw(r) + 1] == (hi | 32'(kept)), "R4 control write-back", mem[dw(r) + 1],
          hi | 32'(kept));
      for (int j = 0; j < 64 && bad < 0; j++) begin
         got = mem[bw(r) + j / 4][8 * (j % 4) +: 8];
         if (j < kept  && got !== pat + 8'(j)) bad = j;
         if (j >= kept && got !== 8'hEE)       bad = j;
      end
      chk(bad < 0, "R3 buffer bytes and untouched tail", 32'(bad), 32'hFFFF_FFFF);
   endtask

   initial begin
      int r = 0, snap_req, snap_rdy;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      for (int i = 0; i < 4; i++) begin
         mem[dw(i) + 2] = 32'(bw(i) * 4);
         mem[dw(i) + 3] = 32'(dw((i + 1) % 4) * 4);
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(s_ready == 1'b0, "R1 s_ready low after reset", 32'(s_ready), 0);
      chk(mem_req == 1'b0, "R1 mem_req low after reset", 32'(mem_req), 0);
      rst_n = 1'b1;
      @(negedge clk);
      arm(0, 32'hE000_0040);
      csr(2'd0, 32'h1);
      s_valid = 1'b1; s_data = 8'h55;
      snap_req = req_total;
      repeat (20) @(negedge clk);
      chk(req_total == snap_req, "R1 no access before first strobe", 32'(req_total - snap_req), 0);
      s_valid = 1'b0;
      csr(2'd2, 32'd60);
      csr(2'd1, 32'(dw(0) * 4));
      csr(2'd0, 32'h3);

      // table walk: R2 R3 R4 R5 R6 R12
      for (int v = 0; v < NV; v++) begin
         logic [7:0] pat = 8'(16 * v + 3);
         stall = V_STALL[v];
         arm(r, (V_LFARM[v] ? 32'hE000_0000 : 32'hC000_0000) | 32'(V_CAP[v]));
         send(V_LEN[v], pat);
         wait_done(r, 3000, "R6 ring completion");
         check_frame(r, V_LEN[v], V_CAP[v], pat, 32'h6000_0000);
         r = (r + 1) % 4;
      end
      stall = 1'b0;

      // R7: not-owned descriptor is refetched each poll interval
      arm(r, 32'h0);
      snap_req = req_total; snap_rdy = rdy_total;
      s_valid = 1'b1; s_data = 8'h90; s_last = 1'b0;
      repeat (150) @(negedge clk);
      chk(req_total - snap_req >= 2 && req_total - snap_req <= 4, "R7 refetch count in 150 cycles",
          32'(req_total - snap_req), 32'd3);
      chk(rdy_total == snap_rdy, "R7 no data taken while not owned", 32'(rdy_total - snap_rdy), 0);
      arm(r, 32'hE000_0040);
      send(10, 8'h90);
      wait_done(r, 3000, "R7 completion after owner set");
      check_frame(r, 10, 64, 8'h90, 32'h6000_0000);
      r = (r + 1) % 4;

      // R8: strobe ends a long poll wait
      csr(2'd2, 32'd1000);
      arm(r, 32'h0);
      s_valid = 1'b1; s_data = 8'hA0;
      repeat (30) @(negedge clk);
      mem[dw(r) + 1] = 32'hE000_0040;
      repeat (100) @(negedge clk);
      chk(mem[dw(r) + 1] == 32'hE000_0040, "R8 still waiting without strobe", mem[dw(r) + 1],
          32'hE000_0040);
      csr(2'd0, 32'h3);
      send(5, 8'hA0);
      wait_done(r, 200, "R8 prompt completion after strobe");
      check_frame(r, 5, 64, 8'hA0, 32'h6000_0000);
      r = (r + 1) % 4;
      csr(2'd2, 32'd60);

      // R13: disabled engine starts no fetch
      csr(2'd0, 32'h0);
      arm(r, 32'hE000_0040);
      snap_req = req_total;
      s_valid = 1'b1; s_data = 8'hB0;
      repeat (40) @(negedge clk);
      chk(req_total == snap_req, "R13 no fetch while disabled", 32'(req_total - snap_req), 0);
      csr(2'd0, 32'h1);
      send(6, 8'hB0);
      wait_done(r, 3000, "R13 completion after re-enable");
      check_frame(r, 6, 64, 8'hB0, 32'h6000_0000);
      r = (r + 1) % 4;

      // R10: final descriptor halts; flag kept in write-back
      arm(r, 32'hF000_0040);
      send(8, 8'hC0);
      wait_done(r, 3000, "R10 final descriptor completion");
      check_frame(r, 8, 64, 8'hC0, 32'h7000_0000);
      r = (r + 1) % 4;
      arm(r, 32'hE000_0040);
      snap_req = req_total; snap_rdy = rdy_total;
      s_valid = 1'b1; s_data = 8'hD0;
      repeat (40) @(negedge clk);
      chk(req_total == snap_req, "R10 no access after halt", 32'(req_total - snap_req), 0);
      chk(rdy_total == snap_rdy, "R10 no s_ready after halt", 32'(rdy_total - snap_rdy), 0);
      s_valid = 1'b0;

      // R11: base reload while halted; R9: strobe with no frame fetches nothing
      if (r == 0) r = 1;
      arm(r, 32'hE000_0040);
      arm(0, 32'hE000_0040);
      csr(2'd1, 32'(dw(0) * 4));
      csr(2'd0, 32'h3);
      snap_req = req_total;
      repeat (30) @(negedge clk);
      chk(req_total == snap_req, "R9 no fetch without pending frame", 32'(req_total - snap_req), 0);
      send(9, 8'hD0);
      wait_done(0, 3000, "R11 frame lands in reloaded descriptor");
      check_frame(0, 9, 64, 8'hD0, 32'h6000_0000);
      chk(mem[dw(r) + 1] == 32'hE000_0040, "R11 old next descriptor untouched", mem[dw(r) + 1],
          32'hE000_0040);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule